// File: doc/BRIEF.md
# Byte Serial Port with Bus Registers

This block is a byte-wide asynchronous serial port that a processor reaches through a small register window on a Wishbone-style slave bus. Software writes bytes into a transmit queue and reads received bytes from a receive queue. A status register reports the fill state of both queues. An interrupt line, masked per source, signals that data is waiting or that the transmit queue has drained.

The serial line uses one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line idles high. Bit timing comes from an oversampling tick that fires once every (divisor + 1) clocks, with sixteen ticks to each bit. The receiver confirms the start bit halfway through it and samples every later bit at its centre. Reset is asynchronous and active low. Its release is synchronised inside the block.

Top module: `byte_uart`

## Requirements
- R1: After reset, `bus_ack` and `irq` are 0, `tx_o` is 1, and the status, divisor and interrupt-enable registers read 0x03, 0x00 and 0x00.
- R2: A transfer is taken once, on the first clock edge that sees `bus_cyc` and `bus_stb` high. `bus_ack` rises one cycle later and stays high while the strobe is held. It drops as soon as `bus_stb` drops. A held strobe never causes a second access.
- R3: Offset 0x18 is an 8-bit divisor register. It can be written and read, and it changes only on a bus write to that offset.
- R4: Offset 0x20 holds two interrupt-enable bits. Bit 0 masks the receive source and bit 1 masks the transmit source. They read back in the same positions, and the upper bits read 0.
- R5: Reads of any offset not mapped for reading return 0, and this includes the write-only offset 0x00. Writes to unmapped offsets are acknowledged and change no register.
- R6: A write to offset 0x00 queues a byte, which is sent as start(0), data bits 0..7 and stop(1). Each bit lasts 16·(divisor+1) clocks, and bytes leave in the order they were written.
- R7: A write to offset 0x00 while the transmit queue is full is acknowledged and discarded.
- R8: A read of offset 0x08 returns the oldest received byte and removes it from the queue.
- R9: A read of offset 0x08 with the receive queue empty returns 0 and removes nothing. A frame that completes while the receive queue is full is dropped.
- R10: The status register at 0x10 reads {0000, tx_full, rx_full, tx_empty, rx_empty}, so bit 0 is receive empty, bit 1 is transmit empty, bit 2 is receive full and bit 3 is transmit full.
- R11: `irq` is high exactly when (receive queue not empty and enable bit 0 set) or (transmit queue empty and enable bit 1 set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while acknowledge is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Strobe |
| bus_ack | output | 1 | Acknowledge, gated by cycle and strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The checker watches a set of properties on every clock. The acknowledge may only rise after a cycle in which cycle and strobe were both high. The divisor stays unchanged whenever no write is on the bus. The transmit line is high whenever the transmitter is idle. The receive queue never reports full and empty together, and the interrupt stays low while both enables are clear. Several behaviours only the bench scenarios can show, because they span many cycles: the bit order and bit timing of frames at two divisor values, a held strobe giving exactly one pop, the queue-full discard on the transmit side and the queue-full drop on the receive side, an empty read that removes nothing, and the read-back values of every register.

// File: rtl/byte_uart_pkg.sv
package byte_uart_pkg;
  localparam int OFS_TXD  = 'h000;
  localparam int OFS_RXD  = 'h008;
  localparam int OFS_STAT = 'h010;
  localparam int OFS_DIV  = 'h018;
  localparam int OFS_IEN  = 'h020;

  typedef enum logic {BUS_IDLE, BUS_ACK} bus_st_t;
  typedef enum logic {TX_IDLE, TX_SHIFT} tx_st_t;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/uart_tick.sv
module uart_tick #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] div,
  output logic          tick
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign tick  = (cnt_q >= div);
  assign cnt_d = tick ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import byte_uart_pkg::*;
#(
  parameter int W     = 8,
  parameter int TICKS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         avail,
  input  logic [W-1:0] din,
  output logic         pop,
  output logic         txd,
  output logic         busy
);
  localparam int FW  = W + 2;
  localparam int TCW = $clog2(TICKS);
  localparam int BCW = $clog2(FW);

  tx_st_t         st_q, st_d;
  logic [FW-1:0]  sh_q, sh_d;
  logic [TCW-1:0] tc_q, tc_d;
  logic [BCW-1:0] bc_q, bc_d;

  always_comb begin
    st_d = st_q;
    sh_d = sh_q;
    tc_d = tc_q;
    bc_d = bc_q;
    pop  = 1'b0;
    case (st_q)
      TX_IDLE: if (avail) begin
        pop  = 1'b1;
        sh_d = {1'b1, din, 1'b0};
        tc_d = '0;
        bc_d = '0;
        st_d = TX_SHIFT;
      end
      TX_SHIFT: if (tick) begin
        tc_d = tc_q + 1'b1;
        if (tc_q == TCW'(TICKS-1)) begin
          tc_d = '0;
          sh_d = {1'b1, sh_q[FW-1:1]};
          bc_d = bc_q + 1'b1;
          if (bc_q == BCW'(FW-1)) st_d = TX_IDLE;
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TX_IDLE;
      sh_q <= '1;
      tc_q <= '0;
      bc_q <= '0;
    end else begin
      st_q <= st_d;
      sh_q <= sh_d;
      tc_q <= tc_d;
      bc_q <= bc_d;
    end
  end

  assign txd  = sh_q[0];
  assign busy = (st_q == TX_SHIFT);
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import byte_uart_pkg::*;
#(
  parameter int W     = 8,
  parameter int TICKS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         rxd,
  output logic         push,
  output logic [W-1:0] dout
);
  localparam int TCW = $clog2(TICKS);
  localparam int BCW = $clog2(W);

  rx_st_t         st_q, st_d;
  logic [TCW-1:0] tc_q, tc_d;
  logic [BCW-1:0] bc_q, bc_d;
  logic [W-1:0]   sh_q, sh_d;
  logic           s1_q, s2_q;

  always_comb begin
    st_d = st_q;
    tc_d = tc_q;
    bc_d = bc_q;
    sh_d = sh_q;
    push = 1'b0;
    case (st_q)
      RX_IDLE: if (tick && !s2_q) begin
        tc_d = '0;
        st_d = RX_START;
      end
      RX_START: if (tick) begin
        tc_d = tc_q + 1'b1;
        if (tc_q == TCW'(TICKS/2-1)) begin
          tc_d = '0;
          bc_d = '0;
          st_d = s2_q ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: if (tick) begin
        tc_d = tc_q + 1'b1;
        if (tc_q == TCW'(TICKS-1)) begin
          tc_d = '0;
          sh_d = {s2_q, sh_q[W-1:1]};
          bc_d = bc_q + 1'b1;
          if (bc_q == BCW'(W-1)) st_d = RX_STOP;
        end
      end
      RX_STOP: if (tick) begin
        tc_d = tc_q + 1'b1;
        if (tc_q == TCW'(TICKS-1)) begin
          tc_d = '0;
          push = s2_q;
          st_d = RX_IDLE;
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RX_IDLE;
      tc_q <= '0;
      bc_q <= '0;
      sh_q <= '0;
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      st_q <= st_d;
      tc_q <= tc_d;
      bc_q <= bc_d;
      sh_q <= sh_d;
      s1_q <= rxd;
      s2_q <= s1_q;
    end
  end

  assign dout = sh_q;
endmodule

// File: rtl/byte_uart.sv
module byte_uart
  import byte_uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int DW         = 8,
  parameter int AW         = 12,
  parameter int OVS        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          tx_o,
  input  logic          rx_i,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          bus_we,
  input  logic          bus_cyc,
  input  logic          bus_stb,
  output logic          bus_ack,
  output logic          irq
);
  logic [1:0]    rs_q;
  logic          rst_i_n;
  bus_st_t       st_q, st_d;
  logic          ack_q, ack_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic [DW-1:0] div_q, div_d;
  logic [1:0]    ien_q, ien_d;
  logic          hit, wr, rd;
  logic          tick;
  logic          tx_push, tx_pop, tx_empty, tx_full, tx_busy;
  logic [DW-1:0] tx_dout;
  logic          rx_push, rx_pop, rx_empty, rx_full;
  logic [DW-1:0] rx_din, rx_dout;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign hit     = bus_cyc & bus_stb & (st_q == BUS_IDLE);
  assign wr      = hit & bus_we;
  assign rd      = hit & ~bus_we;
  assign tx_push = wr & (bus_addr == AW'(OFS_TXD));
  assign rx_pop  = rd & (bus_addr == AW'(OFS_RXD));

  always_comb begin
    st_d    = st_q;
    ack_d   = ack_q;
    rdata_d = rdata_q;
    div_d   = div_q;
    ien_d   = ien_q;
    case (st_q)
      BUS_IDLE: if (bus_cyc && bus_stb) begin
        ack_d = 1'b1;
        st_d  = BUS_ACK;
        if (bus_we) begin
          if (bus_addr == AW'(OFS_DIV)) div_d = bus_wdata;
          if (bus_addr == AW'(OFS_IEN)) ien_d = bus_wdata[1:0];
        end else begin
          case (bus_addr)
            AW'(OFS_RXD):  rdata_d = rx_empty ? '0 : rx_dout;
            AW'(OFS_STAT): rdata_d = {{(DW-4){1'b0}}, tx_full, rx_full, tx_empty, rx_empty};
            AW'(OFS_DIV):  rdata_d = div_q;
            AW'(OFS_IEN):  rdata_d = {{(DW-2){1'b0}}, ien_q};
            default:       rdata_d = '0;
          endcase
        end
      end
      BUS_ACK: if (!bus_stb) begin
        ack_d = 1'b0;
        st_d  = BUS_IDLE;
      end
      default: st_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= BUS_IDLE;
      ack_q   <= 1'b0;
      rdata_q <= '0;
      div_q   <= '0;
      ien_q   <= '0;
    end else begin
      st_q    <= st_d;
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
      div_q   <= div_d;
      ien_q   <= ien_d;
    end
  end

  assign bus_ack   = ack_q & bus_cyc & bus_stb;
  assign bus_rdata = rdata_q;
  assign irq       = (~rx_empty & ien_q[0]) | (tx_empty & ien_q[1]);

  uart_tick #(.CW(DW)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .div(div_q), .tick(tick)
  );

  uart_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_txq (
    .clk(clk), .rst_n(rst_i_n), .push(tx_push), .din(bus_wdata),
    .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full)
  );

  uart_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_rxq (
    .clk(clk), .rst_n(rst_i_n), .push(rx_push), .din(rx_din),
    .pop(rx_pop), .dout(rx_dout), .empty(rx_empty), .full(rx_full)
  );

  uart_tx #(.W(DW), .TICKS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .avail(~tx_empty), .din(tx_dout),
    .pop(tx_pop), .txd(tx_o), .busy(tx_busy)
  );

  uart_rx #(.W(DW), .TICKS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .rxd(rx_i),
    .push(rx_push), .dout(rx_din)
  );
endmodule

// File: rtl/byte_uart_chk.sv
module byte_uart_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_cyc,
  input logic          bus_stb,
  input logic          bus_we,
  input logic          bus_ack,
  input logic          tx_o,
  input logic          tx_busy,
  input logic          rx_empty,
  input logic          rx_full,
  input logic [1:0]    ien_q,
  input logic [DW-1:0] div_q,
  input logic          irq
);
  // R2
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> $past(bus_cyc && bus_stb));

  // R3
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cyc && bus_stb && bus_we) |=> $stable(div_q));

  // R6
  line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_o);

  // R9
  rx_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_empty);

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 2'b00) |-> !irq);
endmodule

bind byte_uart byte_uart_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
  .bus_we(bus_we), .bus_ack(bus_ack), .tx_o(tx_o), .tx_busy(tx_busy),
  .rx_empty(rx_empty), .rx_full(rx_full), .ien_q(ien_q), .div_q(div_q),
  .irq(irq)
);

// File: tb/byte_uart_tb.sv
module byte_uart_tb;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_o, rx_i = 1'b1;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic        we = 1'b0, cyc = 1'b0, stb = 1'b0;
  logic        ack, irq;

  int n_chk = 0, n_err = 0;
  int bit_clks = 16;
  bit done = 1'b0;
  logic [7:0] mon_q[$];
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  byte_uart #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_o(tx_o), .rx_i(rx_i),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .bus_we(we), .bus_cyc(cyc), .bus_stb(stb), .bus_ack(ack), .irq(irq)
  );

  function automatic int exp_stat(bit rxe, bit txe, bit rxf, bit txf);
    return {txf, rxf, txe, rxe};
  endfunction

  function automatic bit exp_irq(bit rx_has, bit tx_mt, logic [1:0] en);
    return (rx_has & en[0]) | (tx_mt & en[1]);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [11:0] a, input logic [7:0] d,
                      output logic [7:0] q);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; addr = a; wdata = d;
    do @(negedge clk); while (!ack);
    q = rdata;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    logic [7:0] q;
    xfer(1'b1, a, d, q);
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] q);
    xfer(1'b0, a, 8'h00, q);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_i = 1'b0;
    repeat (bit_clks) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      repeat (bit_clks) @(negedge clk);
    end
    rx_i = 1'b1;
    repeat (bit_clks + 4) @(negedge clk);
  endtask

  task automatic compare_tx(string req);
    chk({req, " frame count"}, mon_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < mon_q.size(); i++)
      chk({req, " frame byte"}, mon_q[i], exp_q[i]);
    mon_q.delete();
    exp_q.delete();
  endtask

  // serial line monitor: decodes frames on tx_o at bit centres (R6)
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (rst_n && tx_o === 1'b0) begin
        repeat (bit_clks/2 - 1) @(negedge clk);
        chk("R6 start bit", tx_o, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (bit_clks) @(negedge clk);
          b[i] = tx_o;
        end
        repeat (bit_clks) @(negedge clk);
        chk("R6 stop bit", tx_o, 1);
        mon_q.push_back(b);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    logic [7:0] b[6];
    logic [7:0] r;
    void'($urandom(32'd7321));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 ack", ack, 0);
    chk("R1 tx line", tx_o, 1);
    chk("R1 irq", irq, 0);
    rd(12'h010, q); chk("R1 R10 status", q, exp_stat(1, 1, 0, 0));
    rd(12'h018, q); chk("R1 divisor", q, 0);
    rd(12'h020, q); chk("R1 enables", q, 0);

    // R3 divisor
    wr(12'h018, 8'hA5);
    rd(12'h018, q); chk("R3 divisor", q, 8'hA5);
    wr(12'h018, 8'h00);
    rd(12'h018, q); chk("R3 divisor", q, 8'h00);

    // R4 enables, R11 interrupt
    wr(12'h020, 8'hFF);
    rd(12'h020, q); chk("R4 enables", q, 8'h03);
    chk("R11 irq tx empty", irq, exp_irq(0, 1, 2'b11));
    wr(12'h020, 8'h01);
    chk("R11 irq masked", irq, exp_irq(0, 1, 2'b01));

    // R5 unmapped
    wr(12'h028, 8'h55);
    wr(12'h004, 8'h77);
    rd(12'h018, q); chk("R5 divisor untouched", q, 0);
    rd(12'h020, q); chk("R5 enables untouched", q, 1);
    rd(12'h030, q); chk("R5 unmapped read", q, 0);
    rd(12'h000, q); chk("R5 write-only read", q, 0);
    repeat (20 * bit_clks) @(negedge clk);
    chk("R5 no frame from unmapped write", mon_q.size(), 0);

    // R9 empty read
    rd(12'h008, q); chk("R9 empty read", q, 0);
    rd(12'h010, q); chk("R9 R10 status after empty read", q, exp_stat(1, 1, 0, 0));

    // R8 receive
    send_byte(8'h3C);
    chk("R11 irq rx data", irq, exp_irq(1, 1, 2'b01));
    rd(12'h010, q); chk("R10 status rx data", q, exp_stat(0, 1, 0, 0));
    rd(12'h008, q); chk("R8 rx byte", q, 8'h3C);
    rd(12'h010, q); chk("R8 status after pop", q, exp_stat(1, 1, 0, 0));

    // R2 held strobe: one pop only
    send_byte(8'h11);
    send_byte(8'h22);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; addr = 12'h008;
    #1 chk("R2 ack not yet", ack, 0);
    @(negedge clk);
    chk("R2 ack one cycle later", ack, 1);
    chk("R2 R8 held read data", rdata, 8'h11);
    repeat (3) @(negedge clk);
    chk("R2 ack held", ack, 1);
    stb = 1'b0; cyc = 1'b0;
    #1 chk("R2 ack drops with strobe", ack, 0);
    @(negedge clk);
    rd(12'h008, q); chk("R2 single pop", q, 8'h22);

    // R9 receive full drop
    for (int i = 0; i < DEPTH + 1; i++) begin
      b[i] = 8'(8'h40 + i * 8'h13);
      send_byte(b[i]);
    end
    rd(12'h010, q); chk("R10 status rx full", q, exp_stat(0, 1, 1, 0));
    for (int i = 0; i < DEPTH; i++) begin
      rd(12'h008, q); chk("R9 rx order", q, b[i]);
    end
    rd(12'h008, q); chk("R9 dropped frame", q, 0);

    // R6 R7 transmit, full queue discard
    wr(12'h020, 8'h00);
    for (int i = 0; i < 6; i++) b[i] = 8'($urandom);
    for (int i = 0; i < DEPTH + 1; i++) begin
      wr(12'h000, b[i]);
      exp_q.push_back(b[i]);
    end
    rd(12'h010, q); chk("R7 R10 status tx full", q, exp_stat(1, 0, 0, 1));
    wr(12'h000, b[DEPTH + 1]);
    repeat ((DEPTH + 2) * 10 * bit_clks + 100) @(negedge clk);
    compare_tx("R7");
    rd(12'h010, q); chk("R6 status drained", q, exp_stat(1, 1, 0, 0));

    // R6 R8 random bytes at other divisors
    for (int d = 1; d <= 3; d += 2) begin
      wr(12'h018, 8'(d));
      bit_clks = 16 * (d + 1);
      rd(12'h018, q); chk("R3 divisor set", q, d);
      for (int k = 0; k < 4; k++) begin
        r = 8'($urandom);
        wr(12'h000, r);
        exp_q.push_back(r);
        r = 8'($urandom);
        send_byte(r);
        rd(12'h008, q); chk("R8 random rx", q, r);
      end
      repeat (20 * bit_clks + 100) @(negedge clk);
      compare_tx("R6");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule